// File: doc/BRIEF.md
# In-Order Retirement Sequencer

The retirement sequencer looks at the one instruction in the writeback slot each cycle and decides what happens to it. Only three outcomes are possible. The first is a fault, which delivers a precise exception. The second is a handler call, a serializing jump into privileged firmware mode. The third is a normal commit, which publishes the instruction's store, trains the branch predictor and counts the instruction as retired. Every outcome is registered, so the action and its payload are valid for exactly one cycle after the edge that sampled the slot.

The priority is fixed. A fault wins over a handler call, and a handler call wins over store commit and predictor training. For a handler call the block builds the entry vector from a firmware base register and the function code. It also supplies the return address. When a handler-return instruction commits, the block asks for a full flush and gives the resume address. Its exit strobe tells the surrounding core to leave firmware mode, drop this CPU's load-linked reservations and switch off the shadow registers. Memory, the predictor and the firmware itself sit outside this block.

Instruction encoding: bits [31:26] hold the major opcode. Opcode 6'h00 is a handler call, and its function code sits in bits [7:0]. Opcode 6'h1E is a handler return. Every other opcode is an ordinary instruction.

Top module: `retire_seq`

## Requirements
- R1: When `slot_vld` is low, no action, strobe, flush or discard is raised in the following cycle and `retired_cnt` holds, whatever the other slot inputs are. After reset every output is zero.
- R2: A valid slot with `slot_fault` high gives `act_fault` for one cycle, carrying `slot_trap`, `slot_fva` and `slot_pc`. It also raises `discard_pending` and `flush_all`, and suppresses the memory write, the reservation break, the predictor update and the retire count.
- R3: A fault takes precedence over a handler call and over a store. A faulting slot that holds a handler-call opcode and the store flag still produces only the fault outcome.
- R4: A valid, non-faulting handler call with a legal function gives `act_call` for one cycle. It carries the function code, the call PC in `act_pc` and `act_ret_addr` = call PC + 4. It raises `discard_pending` and `flush_all`. It does not write memory, train the predictor or count as retired, even if the store or taken flags are set.
- R5: For a function code 0x00–0x3F the vector is {base[63:15], 15'h2000 + (func[5:0] << 6)} with bit 0 set.
- R6: For a function code 0x80–0xBF the vector is {base[63:15], 15'h3000 + (func[5:0] << 6)} with bit 0 set.
- R7: A handler call whose function code is outside both ranges (0x40–0x7F, 0xC0–0xFF) is delivered as a fault. The trap code is `TRAP_ILLEGAL` (8'h13), the fault address is zero and the PC is the slot PC.
- R8: A normal commit with the store flag set raises `mem_we` with `slot_pa` and `slot_data`. In the same cycle it raises `resv_break` with the cache-line address (`slot_pa` with its low `LINE_LG` bits cleared). `act_commit` is asserted and `retired_cnt` increments.
- R9: `pred_we` is raised with the slot PC and branch target only on a normal commit whose branch was taken. A not-taken branch leaves `pred_we` low.
- R10: A committing handler return raises `act_commit`, increments the counter, and raises `exit_fire`, `flush_all` and `discard_pending`. `exit_pc` is `saved_pc` with bit 0 cleared.
- R11: At most one of `act_fault`, `act_call`, `act_commit` is high in any cycle. Each lasts one cycle unless the next slot produces the same outcome.
- R12: `retired_cnt` counts committed instructions modulo 2^`CNTW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | Writeback slot holds an instruction |
| slot_fault | input | 1 | Instruction carries a pending exception |
| slot_trap | input | TRAPW | Exception class code |
| slot_fva | input | AW | Faulting virtual address |
| slot_pc | input | AW | Instruction PC |
| slot_insn | input | 32 | Raw instruction bits |
| slot_store | input | 1 | Instruction has store semantics |
| slot_pa | input | AW | Store physical address |
| slot_data | input | DW | Store data |
| slot_br_taken | input | 1 | Branch resolved taken |
| slot_br_target | input | AW | Branch target |
| hbase | input | AW | Firmware base register |
| saved_pc | input | AW | Saved exception return address |
| act_fault | output | 1 | Fault outcome |
| act_call | output | 1 | Handler-call outcome |
| act_commit | output | 1 | Normal commit outcome |
| act_trap | output | TRAPW | Trap code of fault |
| act_fva | output | AW | Fault virtual address |
| act_pc | output | AW | Faulting or calling PC |
| act_func | output | 8 | Handler function code |
| act_vector | output | AW | Handler entry vector |
| act_ret_addr | output | AW | Return address of call |
| mem_we | output | 1 | Store write strobe |
| mem_addr | output | AW | Store address |
| mem_wdata | output | DW | Store data |
| resv_break | output | 1 | Break reservations on a line |
| resv_line | output | AW | Line address to break |
| pred_we | output | 1 | Predictor update strobe |
| pred_pc | output | AW | Branch PC |
| pred_target | output | AW | Branch target |
| retired_cnt | output | CNTW | Retired instruction count |
| discard_pending | output | 1 | Drop the deferred result |
| flush_all | output | 1 | Full pipeline flush |
| exit_fire | output | 1 | Leave firmware mode, clear own reservations and shadow registers |
| exit_pc | output | AW | Resume PC after handler return |

## Verification
The bench builds the block with `CNTW` = 4 and `LINE_LG` = 5, keeping the 64-bit address and data defaults. The narrow counter lets twenty commits carry it through a wrap, which exercises R12 at the modulo boundary. The 32-byte line makes the reservation-break address visibly differ from the store address for an unaligned `slot_pa`. Full-width addresses keep the base-register bits above bit 15 under test in every vector.

// File: rtl/retire_pkg.sv
package retire_pkg;

  localparam logic [5:0] OPC_HCALL = 6'h00;
  localparam logic [5:0] OPC_HRET  = 6'h1E;

  typedef enum logic [1:0] {
    FC_PRIV   = 2'd0,
    FC_UNPRIV = 2'd1,
    FC_BAD    = 2'd2
  } fcls_e;

  // function code class: 0x00-0x3F privileged, 0x80-0xBF unprivileged
  function automatic fcls_e fn_class(input logic [7:0] f);
    case (f[7:6])
      2'b00:   return FC_PRIV;
      2'b10:   return FC_UNPRIV;
      default: return FC_BAD;
    endcase
  endfunction

  // 15-bit offset below the base register's kept bits
  function automatic logic [14:0] fn_offset(input logic [7:0] f);
    logic [14:0] region;
    region = f[7] ? 15'h3000 : 15'h2000;
    return region | {3'b000, f[5:0], 6'b000000};
  endfunction

endpackage

// File: rtl/retire_decode.sv
module retire_decode
  import retire_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   insn,
  input  logic [AW-1:0] hbase,
  input  logic [AW-1:0] pc,
  output logic          is_hcall,
  output logic          is_hret,
  output logic          fn_legal,
  output logic [7:0]    fn_code,
  output logic [AW-1:0] vector,
  output logic [AW-1:0] ret_addr
);

  logic [5:0]  opc;
  logic [14:0] off;
  fcls_e       cls;
  logic        unused_bits;

  assign opc         = insn[31:26];
  assign fn_code     = insn[7:0];
  assign unused_bits = ^{insn[25:8], hbase[14:0], off[0]};

  always_comb begin
    cls      = fn_class(fn_code);
    off      = fn_offset(fn_code);
    is_hcall = (opc == OPC_HCALL);
    is_hret  = (opc == OPC_HRET);
    fn_legal = (cls != FC_BAD);
  end

  // entry vector: base high bits, computed offset, mode bit 0 set
  assign vector   = {hbase[AW-1:15], off[14:1], 1'b1};
  assign ret_addr = pc + AW'(4);

  // R5: privileged range lands in the 0x2000 region
  a_r5_priv_region: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hcall && insn[7:6] == 2'b00) |-> (vector[14:12] == 3'b010 && vector[0]));

  // R6: unprivileged range lands in the 0x3000 region
  a_r6_unpriv_region: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hcall && insn[7:6] == 2'b10) |-> (vector[14:12] == 3'b011 && vector[0]));

endmodule

// File: rtl/retire_prio.sv
module retire_prio #(
  parameter int                AW           = 64,
  parameter int                DW           = 64,
  parameter int                TRAPW        = 8,
  parameter int                LINE_LG      = 6,
  parameter logic [TRAPW-1:0]  TRAP_ILLEGAL = 'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             fault,
  input  logic [TRAPW-1:0] trap,
  input  logic [AW-1:0]    fva,
  input  logic [AW-1:0]    pc,
  input  logic             is_hcall,
  input  logic             is_hret,
  input  logic             fn_legal,
  input  logic [7:0]       fn_code,
  input  logic [AW-1:0]    vector,
  input  logic [AW-1:0]    ret_addr,
  input  logic             is_store,
  input  logic [AW-1:0]    pa,
  input  logic [DW-1:0]    data,
  input  logic             br_taken,
  input  logic [AW-1:0]    br_target,
  input  logic [AW-1:0]    saved_pc,
  output logic             take_fault,
  output logic             take_call,
  output logic             take_commit,
  output logic [TRAPW-1:0] n_trap,
  output logic [AW-1:0]    n_fva,
  output logic [AW-1:0]    n_pc,
  output logic [7:0]       n_func,
  output logic [AW-1:0]    n_vector,
  output logic [AW-1:0]    n_ret,
  output logic             n_mem_we,
  output logic [AW-1:0]    n_mem_addr,
  output logic [DW-1:0]    n_mem_data,
  output logic             n_rb,
  output logic [AW-1:0]    n_line,
  output logic             n_pred_we,
  output logic [AW-1:0]    n_pred_pc,
  output logic [AW-1:0]    n_pred_tgt,
  output logic             n_flush,
  output logic             n_exit,
  output logic [AW-1:0]    n_exit_pc
);

  localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << LINE_LG) - AW'(1));

  logic bad_call;
  logic is_exit;

  // strict order: fault, handler call, commit side effects
  always_comb begin
    bad_call    = is_hcall && !fn_legal;
    take_fault  = vld && (fault || bad_call);
    take_call   = vld && !fault && is_hcall && fn_legal;
    take_commit = vld && !fault && !is_hcall;
    is_exit     = take_commit && is_hret;
  end

  always_comb begin
    n_trap     = take_fault ? (fault ? trap : TRAP_ILLEGAL) : '0;
    n_fva      = (take_fault && fault) ? fva : '0;
    n_pc       = (take_fault || take_call) ? pc : '0;
    n_func     = take_call ? fn_code : '0;
    n_vector   = take_call ? vector : '0;
    n_ret      = take_call ? ret_addr : '0;
    n_mem_we   = take_commit && is_store;
    n_mem_addr = n_mem_we ? pa : '0;
    n_mem_data = n_mem_we ? data : '0;
    n_rb       = n_mem_we;
    n_line     = n_mem_we ? (pa & LINE_MASK) : '0;
    n_pred_we  = take_commit && br_taken;
    n_pred_pc  = n_pred_we ? pc : '0;
    n_pred_tgt = n_pred_we ? br_target : '0;
    n_exit     = is_exit;
    n_exit_pc  = is_exit ? {saved_pc[AW-1:1], 1'b0} : '0;
    n_flush    = take_fault || take_call || is_exit;
  end

  // R3: a fault never lets a store or a call through
  a_r3_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && fault) |-> (!n_mem_we && !take_call && !n_pred_we));

  // R7: illegal function code becomes a fault, not a call
  a_r7_bad_func: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && is_hcall && !fn_legal) |-> (take_fault && !take_call));

endmodule

// File: rtl/retire_out.sv
module retire_out #(
  parameter int AW    = 64,
  parameter int DW    = 64,
  parameter int TRAPW = 8,
  parameter int CNTW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_fault,
  input  logic             take_call,
  input  logic             take_commit,
  input  logic [TRAPW-1:0] n_trap,
  input  logic [AW-1:0]    n_fva,
  input  logic [AW-1:0]    n_pc,
  input  logic [7:0]       n_func,
  input  logic [AW-1:0]    n_vector,
  input  logic [AW-1:0]    n_ret,
  input  logic             n_mem_we,
  input  logic [AW-1:0]    n_mem_addr,
  input  logic [DW-1:0]    n_mem_data,
  input  logic             n_rb,
  input  logic [AW-1:0]    n_line,
  input  logic             n_pred_we,
  input  logic [AW-1:0]    n_pred_pc,
  input  logic [AW-1:0]    n_pred_tgt,
  input  logic             n_flush,
  input  logic             n_exit,
  input  logic [AW-1:0]    n_exit_pc,
  output logic             act_fault,
  output logic             act_call,
  output logic             act_commit,
  output logic [TRAPW-1:0] act_trap,
  output logic [AW-1:0]    act_fva,
  output logic [AW-1:0]    act_pc,
  output logic [7:0]       act_func,
  output logic [AW-1:0]    act_vector,
  output logic [AW-1:0]    act_ret_addr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             resv_break,
  output logic [AW-1:0]    resv_line,
  output logic             pred_we,
  output logic [AW-1:0]    pred_pc,
  output logic [AW-1:0]    pred_target,
  output logic [CNTW-1:0]  retired_cnt,
  output logic             discard_pending,
  output logic             flush_all,
  output logic             exit_fire,
  output logic [AW-1:0]    exit_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_fault       <= 1'b0;
      act_call        <= 1'b0;
      act_commit      <= 1'b0;
      act_trap        <= '0;
      act_fva         <= '0;
      act_pc          <= '0;
      act_func        <= '0;
      act_vector      <= '0;
      act_ret_addr    <= '0;
      mem_we          <= 1'b0;
      mem_addr        <= '0;
      mem_wdata       <= '0;
      resv_break      <= 1'b0;
      resv_line       <= '0;
      pred_we         <= 1'b0;
      pred_pc         <= '0;
      pred_target     <= '0;
      retired_cnt     <= '0;
      discard_pending <= 1'b0;
      flush_all       <= 1'b0;
      exit_fire       <= 1'b0;
      exit_pc         <= '0;
    end else begin
      act_fault       <= take_fault;
      act_call        <= take_call;
      act_commit      <= take_commit;
      act_trap        <= n_trap;
      act_fva         <= n_fva;
      act_pc          <= n_pc;
      act_func        <= n_func;
      act_vector      <= n_vector;
      act_ret_addr    <= n_ret;
      mem_we          <= n_mem_we;
      mem_addr        <= n_mem_addr;
      mem_wdata       <= n_mem_data;
      resv_break      <= n_rb;
      resv_line       <= n_line;
      pred_we         <= n_pred_we;
      pred_pc         <= n_pred_pc;
      pred_target     <= n_pred_tgt;
      discard_pending <= n_flush;
      flush_all       <= n_flush;
      exit_fire       <= n_exit;
      exit_pc         <= n_exit_pc;
      if (take_commit) retired_cnt <= retired_cnt + CNTW'(1);
    end
  end

  // R11: one outcome at most per cycle
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fault, act_call, act_commit}));

  // R2: fault suppresses every commit side effect and flushes
  a_r2_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    act_fault |-> (!mem_we && !pred_we && !resv_break && flush_all && discard_pending));

  // R4: handler call carries a mode-tagged vector and writes nothing
  a_r4_call_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    act_call |-> (act_vector[0] && !mem_we && !pred_we && flush_all));

  // R12: count moves by one exactly on commit
  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    act_commit |-> (retired_cnt == CNTW'($past(retired_cnt) + CNTW'(1))));

  // R1: no commit, no count change
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !act_commit |-> $stable(retired_cnt));

  // R8: store and reservation break travel together
  a_r8_store_break: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (resv_break && act_commit));

endmodule

// File: rtl/retire_seq.sv
module retire_seq #(
  parameter int               AW           = 64,
  parameter int               DW           = 64,
  parameter int               TRAPW        = 8,
  parameter int               CNTW         = 32,
  parameter int               LINE_LG      = 6,
  parameter logic [TRAPW-1:0] TRAP_ILLEGAL = 'h13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_vld,
  input  logic             slot_fault,
  input  logic [TRAPW-1:0] slot_trap,
  input  logic [AW-1:0]    slot_fva,
  input  logic [AW-1:0]    slot_pc,
  input  logic [31:0]      slot_insn,
  input  logic             slot_store,
  input  logic [AW-1:0]    slot_pa,
  input  logic [DW-1:0]    slot_data,
  input  logic             slot_br_taken,
  input  logic [AW-1:0]    slot_br_target,
  input  logic [AW-1:0]    hbase,
  input  logic [AW-1:0]    saved_pc,
  output logic             act_fault,
  output logic             act_call,
  output logic             act_commit,
  output logic [TRAPW-1:0] act_trap,
  output logic [AW-1:0]    act_fva,
  output logic [AW-1:0]    act_pc,
  output logic [7:0]       act_func,
  output logic [AW-1:0]    act_vector,
  output logic [AW-1:0]    act_ret_addr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             resv_break,
  output logic [AW-1:0]    resv_line,
  output logic             pred_we,
  output logic [AW-1:0]    pred_pc,
  output logic [AW-1:0]    pred_target,
  output logic [CNTW-1:0]  retired_cnt,
  output logic             discard_pending,
  output logic             flush_all,
  output logic             exit_fire,
  output logic [AW-1:0]    exit_pc
);

  logic             is_hcall, is_hret, fn_legal;
  logic [7:0]       fn_code;
  logic [AW-1:0]    vector, ret_addr;
  logic             take_fault, take_call, take_commit;
  logic [TRAPW-1:0] n_trap;
  logic [AW-1:0]    n_fva, n_pc, n_vector, n_ret;
  logic [7:0]       n_func;
  logic             n_mem_we, n_rb, n_pred_we, n_flush, n_exit;
  logic [AW-1:0]    n_mem_addr, n_line, n_pred_pc, n_pred_tgt, n_exit_pc;
  logic [DW-1:0]    n_mem_data;

  retire_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .insn(slot_insn), .hbase(hbase), .pc(slot_pc),
    .is_hcall(is_hcall), .is_hret(is_hret), .fn_legal(fn_legal),
    .fn_code(fn_code), .vector(vector), .ret_addr(ret_addr)
  );

  retire_prio #(
    .AW(AW), .DW(DW), .TRAPW(TRAPW), .LINE_LG(LINE_LG), .TRAP_ILLEGAL(TRAP_ILLEGAL)
  ) u_prio (
    .clk(clk), .rst_n(rst_n), .vld(slot_vld), .fault(slot_fault),
    .trap(slot_trap), .fva(slot_fva), .pc(slot_pc),
    .is_hcall(is_hcall), .is_hret(is_hret), .fn_legal(fn_legal),
    .fn_code(fn_code), .vector(vector), .ret_addr(ret_addr),
    .is_store(slot_store), .pa(slot_pa), .data(slot_data),
    .br_taken(slot_br_taken), .br_target(slot_br_target), .saved_pc(saved_pc),
    .take_fault(take_fault), .take_call(take_call), .take_commit(take_commit),
    .n_trap(n_trap), .n_fva(n_fva), .n_pc(n_pc), .n_func(n_func),
    .n_vector(n_vector), .n_ret(n_ret), .n_mem_we(n_mem_we),
    .n_mem_addr(n_mem_addr), .n_mem_data(n_mem_data), .n_rb(n_rb),
    .n_line(n_line), .n_pred_we(n_pred_we), .n_pred_pc(n_pred_pc),
    .n_pred_tgt(n_pred_tgt), .n_flush(n_flush), .n_exit(n_exit),
    .n_exit_pc(n_exit_pc)
  );

  retire_out #(.AW(AW), .DW(DW), .TRAPW(TRAPW), .CNTW(CNTW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .take_fault(take_fault), .take_call(take_call), .take_commit(take_commit),
    .n_trap(n_trap), .n_fva(n_fva), .n_pc(n_pc), .n_func(n_func),
    .n_vector(n_vector), .n_ret(n_ret), .n_mem_we(n_mem_we),
    .n_mem_addr(n_mem_addr), .n_mem_data(n_mem_data), .n_rb(n_rb),
    .n_line(n_line), .n_pred_we(n_pred_we), .n_pred_pc(n_pred_pc),
    .n_pred_tgt(n_pred_tgt), .n_flush(n_flush), .n_exit(n_exit),
    .n_exit_pc(n_exit_pc),
    .act_fault(act_fault), .act_call(act_call), .act_commit(act_commit),
    .act_trap(act_trap), .act_fva(act_fva), .act_pc(act_pc),
    .act_func(act_func), .act_vector(act_vector), .act_ret_addr(act_ret_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .resv_break(resv_break), .resv_line(resv_line),
    .pred_we(pred_we), .pred_pc(pred_pc), .pred_target(pred_target),
    .retired_cnt(retired_cnt), .discard_pending(discard_pending),
    .flush_all(flush_all), .exit_fire(exit_fire), .exit_pc(exit_pc)
  );

  // R10: handler return commits, flushes and leaves with bit 0 clear
  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
    exit_fire |-> (act_commit && flush_all && !exit_pc[0]));

endmodule

// File: tb/test_retire_seq.sv
module test_retire_seq;

  localparam int CNTW = 4;
  localparam int LINE_LG = 5;

  typedef struct {
    string       tag;
    logic        f, c, a;
    logic [7:0]  trap;
    logic [63:0] fva, pc;
    logic [7:0]  func;
    logic [63:0] vec, ret;
    logic        we;
    logic [63:0] addr, data;
    logic        rb;
    logic [63:0] line;
    logic        pw;
    logic [63:0] ppc, ptg;
    logic [3:0]  cnt;
    logic        flush, ex;
    logic [63:0] expc;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        slot_vld = 0, slot_fault = 0, slot_store = 0, slot_br_taken = 0;
  logic [7:0]  slot_trap = 0;
  logic [63:0] slot_fva = 0, slot_pc = 0, slot_pa = 0, slot_data = 0, slot_br_target = 0;
  logic [31:0] slot_insn = 0;
  logic [63:0] hbase = 64'hABCD_1234_5678_FFFF;
  logic [63:0] saved_pc = 64'h0000_0000_0040_00F1;

  logic        act_fault, act_call, act_commit, mem_we, resv_break, pred_we;
  logic        discard_pending, flush_all, exit_fire;
  logic [7:0]  act_trap, act_func;
  logic [63:0] act_fva, act_pc, act_vector, act_ret_addr, mem_addr, mem_wdata;
  logic [63:0] resv_line, pred_pc, pred_target, exit_pc;
  logic [CNTW-1:0] retired_cnt;

  int nchk = 0, nerr = 0;
  int cnt_model = 0;
  exp_t q[$];
  bit done = 0;

  always #4 clk = ~clk;

  retire_seq #(.CNTW(CNTW), .LINE_LG(LINE_LG)) i_retire_seq (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_fault(slot_fault),
    .slot_trap(slot_trap), .slot_fva(slot_fva), .slot_pc(slot_pc),
    .slot_insn(slot_insn), .slot_store(slot_store), .slot_pa(slot_pa),
    .slot_data(slot_data), .slot_br_taken(slot_br_taken),
    .slot_br_target(slot_br_target), .hbase(hbase), .saved_pc(saved_pc),
    .act_fault(act_fault), .act_call(act_call), .act_commit(act_commit),
    .act_trap(act_trap), .act_fva(act_fva), .act_pc(act_pc),
    .act_func(act_func), .act_vector(act_vector), .act_ret_addr(act_ret_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .resv_break(resv_break), .resv_line(resv_line), .pred_we(pred_we),
    .pred_pc(pred_pc), .pred_target(pred_target), .retired_cnt(retired_cnt),
    .discard_pending(discard_pending), .flush_all(flush_all),
    .exit_fire(exit_fire), .exit_pc(exit_pc)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_call(input logic [7:0] f);
    return {6'h00, 18'h0, f};
  endfunction
  function automatic logic [31:0] mk_ret();
    return {6'h1E, 26'h0};
  endfunction
  function automatic logic [31:0] mk_alu();
    return {6'h10, 26'h0123};
  endfunction

  // entry vector restated as arithmetic on the base
  function automatic logic [63:0] model_vec(input logic [7:0] f);
    logic [63:0] region;
    region = (f >= 8'h80) ? 64'h3000 : 64'h2000;
    return (hbase & ~64'h7FFF) + region + 64'(f % 64) * 64 + 64'd1;
  endfunction

  task automatic drive(input string tag, input logic v, input logic flt,
                       input logic [7:0] trap, input logic [63:0] fva,
                       input logic [63:0] pc, input logic [31:0] insn,
                       input logic st, input logic [63:0] pa, input logic [63:0] dat,
                       input logic bt, input logic [63:0] btg);
    exp_t e;
    logic call, ret, legal;
    @(negedge clk);
    slot_vld = v; slot_fault = flt; slot_trap = trap; slot_fva = fva;
    slot_pc = pc; slot_insn = insn; slot_store = st; slot_pa = pa;
    slot_data = dat; slot_br_taken = bt; slot_br_target = btg;
    e = '{tag: tag, default: '0};
    call  = insn[31:26] == 6'h00;
    ret   = insn[31:26] == 6'h1E;
    legal = (insn[7:0] <= 8'h3F) || (insn[7:0] >= 8'h80 && insn[7:0] <= 8'hBF);
    if (v) begin
      if (flt || (call && !legal)) begin
        e.f = 1; e.trap = flt ? trap : 8'h13; e.fva = flt ? fva : 64'h0;
        e.pc = pc; e.flush = 1;
      end else if (call) begin
        e.c = 1; e.pc = pc; e.func = insn[7:0]; e.vec = model_vec(insn[7:0]);
        e.ret = pc + 64'd4; e.flush = 1;
      end else begin
        e.a = 1; cnt_model = (cnt_model + 1) % 16;
        if (st) begin e.we = 1; e.addr = pa; e.data = dat; e.rb = 1; e.line = pa & ~64'h1F; end
        if (bt) begin e.pw = 1; e.ppc = pc; e.ptg = btg; end
        if (ret) begin e.ex = 1; e.expc = saved_pc & ~64'h1; e.flush = 1; end
      end
    end
    e.cnt = 4'(cnt_model);
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: one expected item per driven cycle, compared after the edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "act_fault", 64'(act_fault), 64'(e.f));
      chk(e.tag, "act_call", 64'(act_call), 64'(e.c));
      chk(e.tag, "act_commit", 64'(act_commit), 64'(e.a));
      chk(e.tag, "act_trap", 64'(act_trap), 64'(e.trap));
      chk(e.tag, "act_fva", act_fva, e.fva);
      chk(e.tag, "act_pc", act_pc, e.pc);
      chk(e.tag, "act_func", 64'(act_func), 64'(e.func));
      chk(e.tag, "act_vector", act_vector, e.vec);
      chk(e.tag, "act_ret_addr", act_ret_addr, e.ret);
      chk(e.tag, "mem_we", 64'(mem_we), 64'(e.we));
      chk(e.tag, "mem_addr", mem_addr, e.addr);
      chk(e.tag, "mem_wdata", mem_wdata, e.data);
      chk(e.tag, "resv_break", 64'(resv_break), 64'(e.rb));
      chk(e.tag, "resv_line", resv_line, e.line);
      chk(e.tag, "pred_we", 64'(pred_we), 64'(e.pw));
      chk(e.tag, "pred_pc", pred_pc, e.ppc);
      chk(e.tag, "pred_target", pred_target, e.ptg);
      chk(e.tag, "retired_cnt", 64'(retired_cnt), 64'(e.cnt));
      chk(e.tag, "flush_all", 64'(flush_all), 64'(e.flush));
      chk(e.tag, "discard_pending", 64'(discard_pending), 64'(e.flush));
      chk(e.tag, "exit_fire", 64'(exit_fire), 64'(e.ex));
      chk(e.tag, "exit_pc", exit_pc, e.expc);
    end
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, all outputs zero
    chk("R1 reset", "actions", 64'({act_fault, act_call, act_commit}), 64'h0);
    chk("R1 reset", "strobes", 64'({mem_we, resv_break, pred_we, flush_all, discard_pending, exit_fire}), 64'h0);
    chk("R1 reset", "retired_cnt", 64'(retired_cnt), 64'h0);
    rst_n = 1;

    // R1: invalid slot with every flag set has no effect
    drive("R1 invalid", 0, 1, 8'h05, 64'h99, 64'h100, mk_call(8'h01), 1, 64'h200, 64'h55, 1, 64'h300);
    // R8: store commit with line-aligned reservation break
    drive("R8 store", 1, 0, 0, 0, 64'h1000, mk_alu(), 1, 64'h1000_0047, 64'hDEAD_BEEF_0123_4567, 0, 0);
    // R9: taken and not-taken branches
    drive("R9 taken", 1, 0, 0, 0, 64'h1004, mk_alu(), 0, 0, 0, 1, 64'h2000);
    drive("R9 not taken", 1, 0, 0, 0, 64'h1008, mk_alu(), 0, 0, 0, 0, 64'h3000);
    drive("R8 R9 store+branch", 1, 0, 0, 0, 64'h100C, mk_alu(), 1, 64'h0000_0000_0000_001F, 64'h77, 1, 64'h4000);
    // R2: fault suppresses store and predictor
    drive("R2 fault", 1, 1, 8'h07, 64'hFFFF_0000_1234_0000, 64'h1010, mk_alu(), 1, 64'h500, 64'h66, 1, 64'h600);
    // R3: fault beats handler call and store
    drive("R3 fault over call", 1, 1, 8'h02, 64'h4444, 64'h1014, mk_call(8'h10), 1, 64'h700, 64'h88, 0, 0);
    // R5: privileged vectors
    drive("R5 call 05", 1, 0, 0, 0, 64'h1018, mk_call(8'h05), 0, 0, 0, 0, 0);
    drive("R5 call 00", 1, 0, 0, 0, 64'h101C, mk_call(8'h00), 0, 0, 0, 0, 0);
    drive("R5 call 3F", 1, 0, 0, 0, 64'h1020, mk_call(8'h3F), 0, 0, 0, 0, 0);
    // R6: unprivileged vectors
    drive("R6 call 80", 1, 0, 0, 0, 64'h1024, mk_call(8'h80), 0, 0, 0, 0, 0);
    drive("R6 call BF", 1, 0, 0, 0, 64'h1028, mk_call(8'hBF), 0, 0, 0, 0, 0);
    // R4: call with store and taken flags still writes nothing
    drive("R4 call quiet", 1, 0, 0, 0, 64'h102C, mk_call(8'h83), 1, 64'h800, 64'h99, 1, 64'h900);
    // R7: illegal function codes at each range edge
    drive("R7 bad 40", 1, 0, 0, 0, 64'h1030, mk_call(8'h40), 0, 0, 0, 0, 0);
    drive("R7 bad 7F", 1, 0, 0, 0, 64'h1034, mk_call(8'h7F), 0, 0, 0, 0, 0);
    drive("R7 bad C0", 1, 0, 0, 0, 64'h1038, mk_call(8'hC0), 1, 64'hA00, 64'h1, 0, 0);
    drive("R7 bad FF", 1, 0, 0, 0, 64'h103C, mk_call(8'hFF), 0, 0, 0, 0, 0);
    // R10: handler return
    drive("R10 return", 1, 0, 0, 0, 64'h1040, mk_ret(), 0, 0, 0, 0, 0);
    // R11: outcomes last one cycle
    idle("R11 drop");
    drive("R11 call", 1, 0, 0, 0, 64'h1044, mk_call(8'h01), 0, 0, 0, 0, 0);
    idle("R11 drop after call");
    // R12: counter wraps with a 4-bit width
    for (int i = 0; i < 20; i++)
      drive("R12 wrap", 1, 0, 0, 0, 64'h2000 + 64'(i * 4), mk_alu(), 0, 0, 0, 0, 0);
    idle("R1 idle end");
    idle("R1 idle end");
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      nerr++;
      $display("FAIL R11 queue: actual %0d expected 0", q.size());
    end
    finish_up();
  end

endmodule